// File: doc/BRIEF.md
# Two-Level Masked Event Interrupt Aggregator

This block gathers single-cycle event pulses from audio ports and turns them into one interrupt line. Events fall into five classes: FIFO underflow (class 0), ring buffer underflow (class 1), ring buffer overflow (class 2), free-mark reached (class 3) and full-mark reached (class 4). Each class holds a status register with one bit per port. A port's status bit latches on its event even when that port is masked, so software can poll events that it does not want to be interrupted by. Masks change only through write-one set and write-one clear strobes, and each mask can be read back.

A second level holds a five-bit summary word. Summary bit k sets while class k has any set status bit that is not masked. The summary word has its own write-one clear and its own mask strobes. The interrupt output is the OR of the summary bits that are not masked. Playback classes (0, 1, 3) have one bit per output port, and the top bit is the digital audio output port. Capture classes (2, 4) have one bit fewer. All registers sit behind a plain word-addressed write port and a combinational read port.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset every status bit, class and summary, reads 0. Every live mask bit reads 1 (masked), and `irq` is low.
- R2: An event pulse on `evt_in` bit c*4+n sets status bit n of class c on the next clock edge, whatever the mask holds.
- R3: Writing the status address of a slot clears each status bit whose data bit is 1. Bits written 0 keep their value.
- R4: When an event and a clear write meet on the same status bit in the same cycle, the bit stays set.
- R5: Writing the mask-set address sets the mask bits whose data bit is 1. Writing the mask-clear address clears them. Bits written 0 are unchanged, and the mask reads back at the mask address.
- R6: Classes 0, 1 and 3 use bits 0..3. Classes 2 and 4 use bits 0..2. Bit 3 of classes 2 and 4 always reads 0 in both status and mask, even after an event or a mask-set write.
- R7: Summary bit k sets on the clock edge after class k holds a set status bit that is not masked. Class status bits that are all masked do not set it.
- R8: The summary status has its own write-one clear and its own mask set and mask clear, and it follows the same set-wins rule as the classes.
- R9: `irq` is high exactly when some summary bit is set and not masked.
- R10: The word address is slot*4+sub. Slots 0..4 are classes 0..4 and slot 5 is the summary. Sub 0 is status (read, write-1 clear), sub 1 is mask (read only), sub 2 is mask set and sub 3 is mask clear. Data sits in the low bits. All other addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 20 | Event pulses, class c port n at bit c*4+n |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address, slot*4+sub |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Aggregated interrupt |

## Verification
The assertions assume that `reg_addr` is stable and known whenever `reg_we` is high. They assume that `evt_in` is driven at every clock edge after reset, and that only one register is written per cycle. The stimulus changes inputs only on the falling edge. It writes at most one address per cycle and keeps event pulses sparse, so that masked, unmasked and cleared states all occur. Some writes are aimed at the unused addresses and the reserved capture bits.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;
   localparam int NUM_CLASSES = 5;
   localparam int NUM_SLOTS   = NUM_CLASSES + 1;
   localparam int REG_ADDR_W  = 5;

   typedef enum logic [2:0] {
      CLS_FIFO_UNDER = 3'd0,
      CLS_RING_UNDER = 3'd1,
      CLS_RING_OVER  = 3'd2,
      CLS_FREE_MARK  = 3'd3,
      CLS_FULL_MARK  = 3'd4
   } evt_class_e;

   typedef enum logic [1:0] {
      SUB_STATUS = 2'd0,
      SUB_MASK   = 2'd1,
      SUB_MSET   = 2'd2,
      SUB_MCLR   = 2'd3
   } sub_reg_e;

   function automatic logic class_is_capture(int cls);
      return (cls == int'(CLS_RING_OVER)) || (cls == int'(CLS_FULL_MARK));
   endfunction
endpackage

// File: rtl/evt_agg_bank.sv
module evt_agg_bank #(
   parameter int               WIDTH = 4,
   parameter logic [WIDTH-1:0] LIVE  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] evt,
   input  logic             clr_we,
   input  logic             mset_we,
   input  logic             mclr_we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] stat,
   output logic [WIDTH-1:0] mask,
   output logic             active
);
   if (WIDTH < 1) begin : g_bad_width
      $error("evt_agg_bank: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stat_q, mask_q, clr_bits, stat_d, mask_d;

   assign clr_bits = clr_we ? wdata : '0;
   // the event term is applied after the clear, so a colliding event wins
   assign stat_d   = ((stat_q & ~clr_bits) | evt) & LIVE;

   always_comb begin
      mask_d = mask_q;
      if (mset_we) mask_d = mask_d | wdata;
      if (mclr_we) mask_d = mask_d & ~wdata;
      mask_d = mask_d & LIVE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= LIVE;
      end else begin
         stat_q <= stat_d;
         mask_q <= mask_d;
      end
   end

   assign stat   = stat_q;
   assign mask   = mask_q;
   assign active = |(stat_q & ~mask_q);
endmodule

// File: rtl/evt_agg_decode.sv
module evt_agg_decode
   import evt_agg_pkg::*;
#(
   parameter int NSLOT  = NUM_SLOTS,
   parameter int DATA_W = 32
) (
   input  logic                         reg_we,
   input  logic [REG_ADDR_W-1:0]        reg_addr,
   input  logic [NSLOT-1:0][DATA_W-1:0] rd_stat,
   input  logic [NSLOT-1:0][DATA_W-1:0] rd_mask,
   output logic [NSLOT-1:0]             clr_we,
   output logic [NSLOT-1:0]             mset_we,
   output logic [NSLOT-1:0]             mclr_we,
   output logic [DATA_W-1:0]            reg_rdata
);
   localparam int SLOT_W = REG_ADDR_W - 2;

   if (NSLOT > (1 << SLOT_W)) begin : g_bad_slots
      $error("evt_agg_decode: address too narrow for NSLOT");
   end

   logic [SLOT_W-1:0] slot;
   sub_reg_e          sub;

   assign slot = reg_addr[REG_ADDR_W-1:2];
   assign sub  = sub_reg_e'(reg_addr[1:0]);

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic hit;
      assign hit        = reg_we && (slot == SLOT_W'(s));
      assign clr_we[s]  = hit && (sub == SUB_STATUS);
      assign mset_we[s] = hit && (sub == SUB_MSET);
      assign mclr_we[s] = hit && (sub == SUB_MCLR);
   end

   always_comb begin
      reg_rdata = '0;
      for (int s = 0; s < NSLOT; s++) begin
         if (slot == SLOT_W'(s)) begin
            if (sub == SUB_STATUS) reg_rdata = rd_stat[s];
            else if (sub == SUB_MASK) reg_rdata = rd_mask[s];
         end
      end
   end
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
   import evt_agg_pkg::*;
#(
   parameter int PLAY_PORTS = 4,
   parameter int CAP_PORTS  = 3,
   parameter int DATA_W     = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_CLASSES*PLAY_PORTS-1:0] evt_in,
   input  logic                              reg_we,
   input  logic [REG_ADDR_W-1:0]             reg_addr,
   input  logic [DATA_W-1:0]                 reg_wdata,
   output logic [DATA_W-1:0]                 reg_rdata,
   output logic                              irq
);
   localparam logic [PLAY_PORTS-1:0] PLAY_LIVE = '1;
   localparam logic [PLAY_PORTS-1:0] CAP_LIVE  = PLAY_PORTS'((1 << CAP_PORTS) - 1);

   if (CAP_PORTS < 1 || CAP_PORTS > PLAY_PORTS) begin : g_bad_cap
      $error("evt_irq_agg: CAP_PORTS must lie in 1..PLAY_PORTS");
   end
   if (PLAY_PORTS >= DATA_W || NUM_CLASSES >= DATA_W) begin : g_bad_data
      $error("evt_irq_agg: DATA_W too narrow");
   end

   logic [NUM_SLOTS-1:0]                  clr_we, mset_we, mclr_we;
   logic [NUM_SLOTS-1:0][DATA_W-1:0]      rd_stat, rd_mask;
   logic [NUM_CLASSES-1:0][PLAY_PORTS-1:0] cls_stat, cls_mask;
   logic [NUM_CLASSES-1:0]                cls_active, sum_stat, sum_mask;
   logic                                  unused_wdata;

   assign unused_wdata = ^reg_wdata[DATA_W-1:PLAY_PORTS];

   for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
      evt_agg_bank #(
         .WIDTH (PLAY_PORTS),
         .LIVE  (class_is_capture(c) ? CAP_LIVE : PLAY_LIVE)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt     (evt_in[c*PLAY_PORTS +: PLAY_PORTS]),
         .clr_we  (clr_we[c]),
         .mset_we (mset_we[c]),
         .mclr_we (mclr_we[c]),
         .wdata   (reg_wdata[PLAY_PORTS-1:0]),
         .stat    (cls_stat[c]),
         .mask    (cls_mask[c]),
         .active  (cls_active[c])
      );
      assign rd_stat[c] = DATA_W'(cls_stat[c]);
      assign rd_mask[c] = DATA_W'(cls_mask[c]);
   end

   evt_agg_bank #(
      .WIDTH (NUM_CLASSES),
      .LIVE  ('1)
   ) u_summary (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (cls_active),
      .clr_we  (clr_we[NUM_CLASSES]),
      .mset_we (mset_we[NUM_CLASSES]),
      .mclr_we (mclr_we[NUM_CLASSES]),
      .wdata   (reg_wdata[NUM_CLASSES-1:0]),
      .stat    (sum_stat),
      .mask    (sum_mask),
      .active  (irq)
   );
   assign rd_stat[NUM_CLASSES] = DATA_W'(sum_stat);
   assign rd_mask[NUM_CLASSES] = DATA_W'(sum_mask);

   evt_agg_decode #(
      .NSLOT  (NUM_SLOTS),
      .DATA_W (DATA_W)
   ) u_decode (
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .rd_stat   (rd_stat),
      .rd_mask   (rd_mask),
      .clr_we    (clr_we),
      .mset_we   (mset_we),
      .mclr_we   (mclr_we),
      .reg_rdata (reg_rdata)
   );
endmodule

// File: rtl/evt_agg_chk.sv
module evt_agg_chk
   import evt_agg_pkg::*;
#(
   parameter int PLAY_PORTS = 4,
   parameter int CAP_PORTS  = 3
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [NUM_CLASSES*PLAY_PORTS-1:0] evt_in,
   input logic                              reg_we,
   input logic [NUM_CLASSES*PLAY_PORTS-1:0] cls_stat,
   input logic [NUM_CLASSES*PLAY_PORTS-1:0] cls_mask,
   input logic [NUM_CLASSES-1:0]            sum_stat,
   input logic [NUM_CLASSES-1:0]            sum_mask,
   input logic                              irq
);
   localparam int TOT = NUM_CLASSES * PLAY_PORTS;

   function automatic logic [TOT-1:0] live_all();
      logic [TOT-1:0] v = '0;
      for (int c = 0; c < NUM_CLASSES; c++)
         for (int n = 0; n < PLAY_PORTS; n++)
            v[c*PLAY_PORTS+n] = class_is_capture(c) ? (n < CAP_PORTS) : 1'b1;
      return v;
   endfunction

   localparam logic [TOT-1:0] LIVE_ALL = live_all();

   logic [TOT-1:0] evt_live;
   assign evt_live = evt_in & LIVE_ALL;

   AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cls_stat == '0) && (sum_stat == '0) && (cls_mask == LIVE_ALL) && (&sum_mask)); // R1
   AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_live) |=> ((cls_stat & $past(evt_live)) == $past(evt_live))); // R2
   AST_STAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_we && !(|evt_live)) |=> (cls_stat == $past(cls_stat))); // R3
   AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_we |=> $stable(cls_mask) && $stable(sum_mask)); // R5
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> ((cls_stat & ~LIVE_ALL) == '0) && ((cls_mask & ~LIVE_ALL) == '0)); // R6
   AST_IRQ_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (&sum_mask) |-> !irq); // R9

   for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_sum
      AST_SUM_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         (|(cls_stat[k*PLAY_PORTS +: PLAY_PORTS] & ~cls_mask[k*PLAY_PORTS +: PLAY_PORTS]))
         |=> sum_stat[k]); // R7
   end
endmodule

bind evt_irq_agg evt_agg_chk #(
   .PLAY_PORTS (PLAY_PORTS),
   .CAP_PORTS  (CAP_PORTS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .evt_in   (evt_in),
   .reg_we   (reg_we),
   .cls_stat (cls_stat),
   .cls_mask (cls_mask),
   .sum_stat (sum_stat),
   .sum_mask (sum_mask),
   .irq      (irq)
);

// File: tb/evt_irq_agg_tb.sv
module evt_irq_agg_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] evt_in = '0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   evt_irq_agg u_dut (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   logic [3:0] m_stat [5];
   logic [3:0] m_mask [5];
   logic [4:0] m_sum, m_smask;

   function automatic logic [3:0] live(int c);
      return (c == 2 || c == 4) ? 4'h7 : 4'hF;
   endfunction

   function automatic logic [31:0] m_read(logic [4:0] a);
      int slot = int'(a[4:2]);
      int sub  = int'(a[1:0]);
      if (slot < 5 && sub == 0) return 32'(m_stat[slot]);
      if (slot < 5 && sub == 1) return 32'(m_mask[slot]);
      if (slot == 5 && sub == 0) return 32'(m_sum);
      if (slot == 5 && sub == 1) return 32'(m_smask);
      return 32'h0;
   endfunction

   task automatic model_reset();
      for (int c = 0; c < 5; c++) begin m_stat[c] = 4'h0; m_mask[c] = live(c); end
      m_sum = 5'h0; m_smask = 5'h1F;
   endtask

   task automatic model_step(logic [19:0] e, logic we, logic [4:0] a, logic [31:0] wd);
      logic [4:0] act;
      int slot = int'(a[4:2]);
      int sub  = int'(a[1:0]);
      for (int k = 0; k < 5; k++) act[k] = |(m_stat[k] & ~m_mask[k]);
      for (int c = 0; c < 5; c++) begin
         logic [3:0] clr = (we && slot == c && sub == 0) ? wd[3:0] : 4'h0;
         m_stat[c] = ((m_stat[c] & ~clr) | e[c*4 +: 4]) & live(c);
         if (we && slot == c && sub == 2) m_mask[c] = m_mask[c] | wd[3:0];
         if (we && slot == c && sub == 3) m_mask[c] = m_mask[c] & ~wd[3:0];
         m_mask[c] = m_mask[c] & live(c);
      end
      begin
         logic [4:0] sclr = (we && slot == 5 && sub == 0) ? wd[4:0] : 5'h0;
         m_sum = (m_sum & ~sclr) | act;
         if (we && slot == 5 && sub == 2) m_smask = m_smask | wd[4:0];
         if (we && slot == 5 && sub == 3) m_smask = m_smask & ~wd[4:0];
      end
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic m_irq();
      return |(m_sum & ~m_smask);
   endfunction

   task automatic cyc(logic [19:0] e, logic we, logic [4:0] a, logic [31:0] wd);
      @(negedge clk);
      chk("R9 irq", 32'(irq), 32'(m_irq()));
      evt_in = e; reg_we = we; reg_addr = a; reg_wdata = wd;
      @(posedge clk);
      model_step(e, we, a, wd);
   endtask

   task automatic rd(logic [4:0] a, string tag);
      @(negedge clk);
      chk("R9 irq", 32'(irq), 32'(m_irq()));
      evt_in = '0; reg_we = 1'b0; reg_addr = a; reg_wdata = '0;
      #1;
      chk(tag, reg_rdata, m_read(a));
      @(posedge clk);
      model_step('0, 1'b0, a, '0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state of every register
      for (int a = 0; a < 24; a++) rd(5'(a), "R1 reset");
      chk("R1 irq low", 32'(irq), 32'h0);

      // R2: masked event still latches; digital output port bit 3 of class 3
      cyc(20'h00001, 1'b0, 5'd0, 32'h0);
      rd(5'd0, "R2 class0 port0");
      cyc(20'h08000, 1'b0, 5'd0, 32'h0);
      rd(5'd12, "R2 class3 port3");
      rd(5'd20, "R7 masked class keeps summary clear");

      // R3: write 0 keeps, write 1 clears
      cyc(20'h0, 1'b1, 5'd0, 32'h0);
      rd(5'd0, "R3 zero write keeps");
      cyc(20'h0, 1'b1, 5'd0, 32'h1);
      rd(5'd0, "R3 one write clears");

      // R4: event and clear on same bit in one cycle
      cyc(20'h00040, 1'b1, 5'd4, 32'h4);
      rd(5'd4, "R4 event wins");

      // R6: reserved capture bit 3
      cyc(20'h00F00, 1'b0, 5'd0, 32'h0);
      rd(5'd8, "R6 capture status bit3");
      cyc(20'h0, 1'b1, 5'd10, 32'hF);
      rd(5'd9, "R6 capture mask bit3");

      // R5: mask clear strobe and readback
      cyc(20'h0, 1'b1, 5'd7, 32'h4);
      rd(5'd5, "R5 mask clear");
      cyc(20'h0, 1'b1, 5'd6, 32'h0);
      rd(5'd5, "R5 zero set write");

      // R7: unmasked class 1 raises summary bit 1
      rd(5'd20, "R7 summary bit1");

      // R8/R9: summary mask and irq
      cyc(20'h0, 1'b1, 5'd23, 32'h2);
      rd(5'd21, "R8 summary mask");
      chk("R9 irq high", 32'(irq), 32'h1);
      cyc(20'h0, 1'b1, 5'd4, 32'h4);
      cyc(20'h0, 1'b1, 5'd20, 32'h2);
      rd(5'd20, "R8 summary clear");
      chk("R9 irq low after clear", 32'(irq), 32'h0);

      // R10: unused addresses ignored
      cyc(20'h0, 1'b1, 5'd30, 32'hFFFF_FFFF);
      rd(5'd30, "R10 unused read");
      for (int a = 0; a < 24; a++) rd(5'(a), "R10 no side effect");

      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic [19:0] e = '0;
         for (int b = 0; b < 20; b++) if (($urandom % 12) == 0) e[b] = 1'b1;
         if (($urandom % 3) == 0)
            cyc(e, 1'b1, 5'($urandom % 32), $urandom);
         else
            cyc(e, 1'b0, 5'($urandom % 32), 32'h0);
         if ((i % 97) == 0)
            for (int a = 0; a < 32; a++) rd(5'(a), "R10 random sweep");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule